// File: doc/BRIEF.md
# Root-Hub Port Status and Control Register Bank

This block holds the 16-bit status and control word of each downstream port of a legacy USB host controller's root hub. There is one word per port, and the number of ports is set by a parameter. Software reaches the bank through a plain register interface. A write strobe, a port select and write data update one port. A separate read select returns any port's word combinationally.

Software writes go through a fixed read-only mask. The two change flags are cleared by writing one to them. Device-side events also update the word: connect (with a low-speed flag), disconnect and remote wakeup. Each event that takes effect sends a one-cycle resume request to the controller's global status logic.

A controller reset input returns every word to its idle value. On the next cycle, every port whose device is still present is reported again through the normal connect path. No stream data passes through this block, so every pin is a plain control or status pin and none uses a handshake.

Top module: `portsc_bank`

## Requirements
- R1: After `rst_n` is released, every port reads 0x0080.
- R2: In every port word, bit 7 always reads one and bits 4 and 5 always read zero.
- R3: A host write to the selected port keeps the bits under mask 0x01BB (bits 0, 1, 3, 4, 5, 7, 8) and loads every other bit from `wr_data`. The other bits include enable (bit 2), resume detect (bit 6), reset (bit 9) and suspend (bit 12).
- R4: Bit 1 (connect change) and bit 3 (enable change) are cleared when the write data holds a one in that position. A zero written to either bit leaves it unchanged.
- R5: A connect event sets bits 0 and 1 and copies `dev_low` into bit 8 (1 means low speed, 0 means full speed).
- R6: A disconnect event works in two parts. If bit 0 is set, it clears bit 0 and sets bit 1. If bit 2 is set, it clears bit 2 and sets bit 3.
- R7: A wakeup request sets bit 6 only when bit 12 is one and bit 6 is zero. In any other state it changes nothing and raises no resume request.
- R8: While `ctrl_rst` is high, every port is loaded with 0x0080 and all other inputs are ignored. In the cycle after, each port with `dev_present` high takes a connect using its `dev_low`.
- R9: `resume_req` is high for exactly one cycle, in the cycle after a connect, a disconnect or an accepted wakeup on any port.
- R10: When several updates reach one port in the same cycle, they apply in this order: host write, then connect, then disconnect, then wakeup.
- R11: `rd_data` shows the word of the port chosen by `rd_sel`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_rst | input | 1 | Synchronous controller reset of all ports |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | SELW | Port written by the host |
| wr_data | input | 16 | Host write data |
| rd_sel | input | SELW | Port read by the host |
| rd_data | output | 16 | Current word of port `rd_sel` |
| dev_present | input | NPORTS | Device attached, per port (level) |
| dev_low | input | NPORTS | Attached device is low speed, per port |
| conn_evt | input | NPORTS | Connect event, one cycle, per port |
| disc_evt | input | NPORTS | Disconnect event, one cycle, per port |
| wake_evt | input | NPORTS | Remote-wakeup request, one cycle, per port |
| resume_req | output | 1 | One-cycle resume request to global status |

## Verification
A wrong stored word shows up on `rd_data` the moment that port is selected. The bench therefore reads every port one cycle after each stimulus, so a bad update is caught within that cycle. A missing or stretched resume pulse is caught on the same cycle from `resume_req`. A wrong ordering of simultaneous updates, or a wakeup wrongly accepted, leaves a bit 6, 1 or 3 that differs from the expected word at the next readback.

// File: rtl/portsc_pkg.sv
package portsc_pkg;
  localparam int WORD_W = 16;

  localparam int B_CONN    = 0;
  localparam int B_CONN_CH = 1;
  localparam int B_EN      = 2;
  localparam int B_EN_CH   = 3;
  localparam int B_RESDET  = 6;
  localparam int B_LOWSPD  = 8;
  localparam int B_SUSP    = 12;

  localparam logic [WORD_W-1:0] HOLD_MASK = 16'h01BB;
  localparam logic [WORD_W-1:0] W1C_MASK  = 16'h000A;
  localparam logic [WORD_W-1:0] IDLE_WORD = 16'h0080;
endpackage

// File: rtl/portsc_cell.sv
module portsc_cell
  import portsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_rst,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              conn_evt,
  input  logic              disc_evt,
  input  logic              wake_evt,
  input  logic              dev_present,
  input  logic              dev_low,
  output logic [WORD_W-1:0] word_q,
  output logic              rerep_q,
  output logic              pulse_q
);
  logic [WORD_W-1:0] word_d;
  logic              fire;
  logic              attach;

  assign attach = conn_evt | (rerep_q & dev_present);

  always_comb begin
    word_d = word_q;
    fire   = 1'b0;
    if (wr_hit) begin
      word_d = (word_q & HOLD_MASK) | (wr_data & ~HOLD_MASK);
      word_d = word_d & ~(wr_data & W1C_MASK);
    end
    if (attach) begin
      word_d[B_CONN]    = 1'b1;
      word_d[B_CONN_CH] = 1'b1;
      word_d[B_LOWSPD]  = dev_low;
      fire              = 1'b1;
    end
    if (disc_evt) begin
      if (word_d[B_CONN]) begin
        word_d[B_CONN]    = 1'b0;
        word_d[B_CONN_CH] = 1'b1;
      end
      if (word_d[B_EN]) begin
        word_d[B_EN]    = 1'b0;
        word_d[B_EN_CH] = 1'b1;
      end
      fire = 1'b1;
    end
    if (wake_evt && word_d[B_SUSP] && !word_d[B_RESDET]) begin
      word_d[B_RESDET] = 1'b1;
      fire             = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= IDLE_WORD;
      rerep_q <= 1'b0;
      pulse_q <= 1'b0;
    end else if (ctrl_rst) begin
      word_q  <= IDLE_WORD;
      rerep_q <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      rerep_q <= 1'b0;
      pulse_q <= fire;
    end
  end
endmodule

// File: rtl/portsc_rdmux.sv
module portsc_rdmux
  import portsc_pkg::*;
#(
  parameter int NPORTS = 2,
  localparam int SELW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic [NPORTS-1:0][WORD_W-1:0] words,
  input  logic [SELW-1:0]               sel,
  output logic [WORD_W-1:0]             dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (sel == SELW'(i)) dout = words[i];
    end
  end
endmodule

// File: rtl/portsc_bank.sv
module portsc_bank
  import portsc_pkg::*;
#(
  parameter int NPORTS = 2,
  localparam int SELW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_rst,
  input  logic              wr_en,
  input  logic [SELW-1:0]   wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SELW-1:0]   rd_sel,
  output logic [WORD_W-1:0] rd_data,
  input  logic [NPORTS-1:0] dev_present,
  input  logic [NPORTS-1:0] dev_low,
  input  logic [NPORTS-1:0] conn_evt,
  input  logic [NPORTS-1:0] disc_evt,
  input  logic [NPORTS-1:0] wake_evt,
  output logic              resume_req
);
  logic [NPORTS-1:0][WORD_W-1:0] words;
  logic [NPORTS-1:0]             rerep;
  logic [NPORTS-1:0]             pulses;

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    portsc_cell u_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_rst    (ctrl_rst),
      .wr_hit      (wr_en && (wr_sel == SELW'(g))),
      .wr_data     (wr_data),
      .conn_evt    (conn_evt[g]),
      .disc_evt    (disc_evt[g]),
      .wake_evt    (wake_evt[g]),
      .dev_present (dev_present[g]),
      .dev_low     (dev_low[g]),
      .word_q      (words[g]),
      .rerep_q     (rerep[g]),
      .pulse_q     (pulses[g])
    );
  end

  portsc_rdmux #(.NPORTS(NPORTS)) u_rdmux (
    .words (words),
    .sel   (rd_sel),
    .dout  (rd_data)
  );

  assign resume_req = |pulses;
endmodule

// File: rtl/portsc_bank_chk.sv
module portsc_bank_chk
  import portsc_pkg::*;
#(
  parameter int NPORTS = 2,
  localparam int SELW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          ctrl_rst,
  input logic                          wr_en,
  input logic [SELW-1:0]               wr_sel,
  input logic [WORD_W-1:0]             wr_data,
  input logic [WORD_W-1:0]             rd_data,
  input logic [NPORTS-1:0]             dev_low,
  input logic [NPORTS-1:0]             conn_evt,
  input logic [NPORTS-1:0]             disc_evt,
  input logic [NPORTS-1:0]             wake_evt,
  input logic                          resume_req,
  input logic [NPORTS-1:0][WORD_W-1:0] words,
  input logic [NPORTS-1:0]             rerep
);
  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] && (rd_data[5:4] == 2'b00)); // R2

  AST_RESUME_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> $past((|conn_evt) || (|disc_evt) || (|wake_evt) || (|rerep))); // R9

  for (genvar g = 0; g < NPORTS; g++) begin : g_chk
    AST_W1C_CONN_CH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SELW'(g) && wr_data[B_CONN_CH] && !conn_evt[g] && !disc_evt[g] && !rerep[g])
      |=> !words[g][B_CONN_CH]); // R4

    AST_HOLD_LOWSPD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SELW'(g) && !conn_evt[g] && !rerep[g] && !ctrl_rst)
      |=> words[g][B_LOWSPD] == $past(words[g][B_LOWSPD])); // R3

    AST_CONNECT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (conn_evt[g] && !disc_evt[g] && !ctrl_rst)
      |=> words[g][B_CONN] && words[g][B_CONN_CH] && (words[g][B_LOWSPD] == $past(dev_low[g]))); // R5

    AST_DISC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (disc_evt[g] && !ctrl_rst) |=> !words[g][B_CONN] && !words[g][B_EN]); // R6

    AST_WAKE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_evt[g] && !words[g][B_SUSP] && !wr_en && !conn_evt[g] && !disc_evt[g] && !rerep[g] && !ctrl_rst)
      |=> $stable(words[g][B_RESDET])); // R7

    AST_CTRL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rst |=> words[g] == IDLE_WORD); // R8
  end
endmodule

bind portsc_bank portsc_bank_chk #(.NPORTS(NPORTS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_rst   (ctrl_rst),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .dev_low    (dev_low),
  .conn_evt   (conn_evt),
  .disc_evt   (disc_evt),
  .wake_evt   (wake_evt),
  .resume_req (resume_req),
  .words      (words),
  .rerep      (rerep)
);

// File: tb/portsc_bank_tb_top.sv
`timescale 1ns/1ps
module portsc_bank_tb_top;
  localparam int NP   = 2;
  localparam int SELW = 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ctrl_rst = 1'b0;
  logic            wr_en = 1'b0;
  logic [SELW-1:0] wr_sel = '0;
  logic [15:0]     wr_data = '0;
  logic [SELW-1:0] rd_sel = '0;
  logic [15:0]     rd_data;
  logic [NP-1:0]   dev_present = '0;
  logic [NP-1:0]   dev_low = '0;
  logic [NP-1:0]   conn_evt = '0;
  logic [NP-1:0]   disc_evt = '0;
  logic [NP-1:0]   wake_evt = '0;
  logic            resume_req;

  always #10 clk = ~clk;

  portsc_bank #(.NPORTS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_rst(ctrl_rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .dev_present(dev_present),
    .dev_low(dev_low), .conn_evt(conn_evt), .disc_evt(disc_evt), .wake_evt(wake_evt),
    .resume_req(resume_req)
  );

  typedef struct {
    bit          is_resume;
    int          port;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 0;
  logic [15:0] m_word [NP];
  bit          m_pend [NP];
  bit          m_res;

  // Model built from the requirements: R3 R4 merge, R10 ordering, R5 R6 R7 events, R8 reset.
  task automatic model_step(input bit we, input int ws, input logic [15:0] wd,
                            input logic [NP-1:0] cn, input logic [NP-1:0] ds,
                            input logic [NP-1:0] wk, input bit cr);
    m_res = 0;
    for (int p = 0; p < NP; p++) begin
      logic [15:0] w;
      bit att;
      if (cr) begin
        m_word[p] = 16'h0080;
        m_pend[p] = 1;
        continue;
      end
      w = m_word[p];
      if (we && ws == p) begin
        w = (w & 16'h01BB) | (wd & 16'hFE44);
        if (wd[1]) w[1] = 0;
        if (wd[3]) w[3] = 0;
      end
      att = cn[p] || (m_pend[p] && dev_present[p]);
      if (att) begin w[0] = 1; w[1] = 1; w[8] = dev_low[p]; m_res = 1; end
      if (ds[p]) begin
        if (w[0]) begin w[0] = 0; w[1] = 1; end
        if (w[2]) begin w[2] = 0; w[3] = 1; end
        m_res = 1;
      end
      if (wk[p] && w[12] && !w[6]) begin w[6] = 1; m_res = 1; end
      m_word[p] = w;
      m_pend[p] = 0;
    end
  endtask

  task automatic push_all(input string tag);
    for (int p = 0; p < NP; p++) sb.push_back('{0, p, m_word[p], tag});
    sb.push_back('{1, 0, {15'd0, m_res}, tag});
    wait (sb.size() == 0);
  endtask

  task automatic step(input bit we, input int ws, input logic [15:0] wd,
                      input logic [NP-1:0] cn, input logic [NP-1:0] ds,
                      input logic [NP-1:0] wk, input bit cr, input string tag);
    @(negedge clk);
    wr_en = we; wr_sel = SELW'(ws); wr_data = wd;
    conn_evt = cn; disc_evt = ds; wake_evt = wk; ctrl_rst = cr;
    @(posedge clk);
    #2;
    wr_en = 0; wr_data = '0; conn_evt = '0; disc_evt = '0; wake_evt = '0; ctrl_rst = 0;
    model_step(we, ws, wd, cn, ds, wk, cr);
    push_all(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 16'h0, '0, '0, '0, 0, tag);
  endtask

  // Monitor: pops expected items and compares them with the outputs (R11 readback).
  initial begin
    forever begin
      item_t it;
      wait (sb.size() > 0);
      it = sb.pop_front();
      n_checks++;
      if (it.is_resume) begin
        #1;
        if (resume_req !== it.exp[0]) begin
          n_fail++;
          $display("FAIL %s resume_req actual=%0b expected=%0b", it.tag, resume_req, it.exp[0]);
        end
      end else begin
        rd_sel = SELW'(it.port);
        #1;
        if (rd_data !== it.exp) begin
          n_fail++;
          $display("FAIL %s port%0d actual=%h expected=%h", it.tag, it.port, rd_data, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin m_word[p] = 16'h0080; m_pend[p] = 0; end
    m_res = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    push_all("R1 reset value");
    step(1, 0, 16'hFFFF, '0, '0, '0, 0, "R3 R2 write all ones");
    step(1, 0, 16'h0000, '0, '0, '0, 0, "R3 write zeros");
    dev_low = 2'b00;
    step(0, 0, 16'h0, 2'b10, '0, '0, 0, "R5 R9 connect full speed p1");
    idle("R9 pulse one cycle");
    step(1, 1, 16'h0000, '0, '0, '0, 0, "R4 zero leaves change bit");
    step(1, 1, 16'h0002, '0, '0, '0, 0, "R4 clear connect change");
    step(1, 1, 16'h0004, '0, '0, '0, 0, "R3 set enable");
    dev_low = 2'b01;
    step(0, 0, 16'h0, 2'b01, '0, '0, 0, "R5 connect low speed p0");
    step(0, 0, 16'h0, '0, 2'b10, '0, 0, "R6 disconnect enabled p1");
    step(1, 1, 16'h0008, '0, '0, '0, 0, "R4 clear enable change");
    step(1, 1, 16'h0002, '0, '0, '0, 0, "R4 clear connect change p1");
    step(0, 0, 16'h0, '0, '0, 2'b01, 0, "R7 wake not suspended");
    step(1, 0, 16'h1183, '0, '0, '0, 0, "R3 set suspend");
    step(0, 0, 16'h0, '0, '0, 2'b01, 0, "R7 wake while suspended");
    step(0, 0, 16'h0, '0, '0, 2'b01, 0, "R7 wake already detected");
    dev_low = 2'b00;
    step(1, 1, 16'h0004, 2'b10, '0, '0, 0, "R10 write then connect");
    step(1, 1, 16'h0006, '0, 2'b10, '0, 0, "R10 write then disconnect");
    step(0, 0, 16'h0, 2'b10, 2'b10, '0, 0, "R10 connect then disconnect");
    dev_present = 2'b01; dev_low = 2'b01;
    step(0, 0, 16'h0, 2'b11, '0, '0, 1, "R8 controller reset ignores events");
    idle("R8 re-report present port");
    idle("R9 quiet after re-report");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule